// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a single-issue processor and decides, every clock, which address the core fetches next. It offers three candidates: the sequential address (current PC plus four), a relative branch target formed from a sign-extended 16-bit word offset, and an absolute jump target that keeps the top four bits of the sequential address. A jump control bit takes priority over everything else. A branch control bit, qualified by the ALU zero flag, takes priority over the sequential path.

The register reloads on the rising clock edge. A synchronous reset loads a parameterised start address. A stall input freezes the register for as long as it is held. The current PC and PC+4 are both brought out, so that fetch and link logic can use them.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the PC is loaded with parameter `RESET_VEC`, which defaults to 0. This takes priority over stall and over all selects.
- R2: With no stall, no jump, and no branch taken, the PC becomes the old PC plus 4 after each rising edge, wrapping modulo 2^32.
- R3: `pc_plus4` always equals `pc` plus 4, modulo 2^32.
- R4: When `branch_en` and `alu_zero` are both 1 and `jump_en` is 0, the next PC is `pc_plus4 + (sign_extend(imm16) << 2)`. Bit 15 of `imm16` is the sign bit.
- R5: When `branch_en` is 1 but `alu_zero` is 0, the branch is not taken and the next PC is `pc_plus4`.
- R6: When `jump_en` is 1, the next PC is `{pc_plus4[31:28], jidx26, 2'b00}`. Jump overrides a taken branch.
- R7: While `stall` is 1 and `rst` is 0, the PC keeps its value across the edge, whatever the select inputs are.
- R8: Bits 1:0 of `pc` are always 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset to RESET_VEC |
| stall | input | 1 | Hold the current PC |
| branch_en | input | 1 | Instruction is a conditional branch |
| alu_zero | input | 1 | ALU equality result |
| jump_en | input | 1 | Instruction is an absolute jump |
| imm16 | input | 16 | Signed word offset for the branch |
| jidx26 | input | 26 | Word index field of the jump |
| pc | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Sequential successor address |

## Verification
A wrong PC register value shows at `pc` and `pc_plus4` in the same cycle. After that the error carries forward, because every later target is built from the same register. A wrong choice of select shows as a wrong `pc` exactly one edge after the inputs are applied. The bench therefore compares `pc` against a model after every edge, so a single bad update is seen at once. Misaligned low bits, or a sign extension of the offset to the wrong width, show up at once with negative offsets and with targets in the top region.

// File: rtl/npc_pkg.sv
package npc_pkg;
   typedef enum logic [1:0] {
      SEL_SEQ = 2'd0,
      SEL_BR  = 2'd1,
      SEL_JMP = 2'd2
   } npc_sel_e;
endpackage

// File: rtl/npc_targets.sv
module npc_targets #(
   parameter int AW = 32,
   parameter int OW = 16,
   parameter int JW = 26,
   parameter int SH = 2
) (
   input  logic [AW-1:0] cur_pc,
   input  logic [OW-1:0] ofs,
   input  logic [JW-1:0] jfield,
   output logic [AW-1:0] seq_addr,
   output logic [AW-1:0] br_addr,
   output logic [AW-1:0] jmp_addr
);
   localparam int KEEP = AW - JW - SH;
   localparam logic [AW-1:0] STEP = AW'(1) << SH;

   initial begin
      if (KEEP < 1) $error("npc_targets: address too narrow for jump field");
      if (OW + SH > AW) $error("npc_targets: offset too wide");
   end

   logic [AW-1:0] sext_ofs;

   always_comb begin
      seq_addr = cur_pc + STEP;
      sext_ofs = {{(AW-OW){ofs[OW-1]}}, ofs};
      br_addr  = seq_addr + (sext_ofs << SH);
      jmp_addr = {seq_addr[AW-1 -: KEEP], jfield, {SH{1'b0}}};
   end
endmodule

// File: rtl/npc_select.sv
module npc_select
   import npc_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          branch_en,
   input  logic          alu_zero,
   input  logic          jump_en,
   input  logic [AW-1:0] seq_addr,
   input  logic [AW-1:0] br_addr,
   input  logic [AW-1:0] jmp_addr,
   output logic [AW-1:0] nxt_addr
);
   npc_sel_e sel;
   logic [AW-1:0] stage1;

   always_comb begin
      if (jump_en) sel = SEL_JMP;
      else if (branch_en && alu_zero) sel = SEL_BR;
      else sel = SEL_SEQ;
   end

   // first stage: the branch or the sequential address
   assign stage1 = (sel == SEL_BR) ? br_addr : seq_addr;
   // second stage: the jump overrides both
   assign nxt_addr = (sel == SEL_JMP) ? jmp_addr : stage1;
endmodule

// File: rtl/npc_reg.sv
module npc_reg #(
   parameter int AW = 32,
   parameter logic [AW-1:0] RESET_VEC = '0,
   parameter bit HAS_STALL = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          hold,
   input  logic [AW-1:0] d,
   output logic [AW-1:0] q
);
   logic upd;

   generate
      if (HAS_STALL) begin : g_stall
         assign upd = ~hold;
      end else begin : g_nostall
         assign upd = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) q <= RESET_VEC;
      else if (upd) q <= d;
   end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
   parameter int AW = 32,
   parameter int OW = 16,
   parameter int JW = 26,
   parameter logic [31:0] RESET_VEC = 32'h0,
   parameter bit HAS_STALL = 1'b1
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        stall,
   input  logic        branch_en,
   input  logic        alu_zero,
   input  logic        jump_en,
   input  logic [15:0] imm16,
   input  logic [25:0] jidx26,
   output logic [31:0] pc,
   output logic [31:0] pc_plus4
);
   localparam int SH = 2;

   initial begin
      if (AW != 32 || OW != 16 || JW != 26)
         $error("npc_unit: port widths are fixed at 32/16/26");
      if (RESET_VEC[SH-1:0] != '0)
         $error("npc_unit: reset vector must be word aligned");
   end

   logic [AW-1:0] seq_a, br_a, jmp_a, nxt_a;

   npc_targets #(.AW(AW), .OW(OW), .JW(JW), .SH(SH)) u_tgt (
      .cur_pc(pc), .ofs(imm16), .jfield(jidx26),
      .seq_addr(seq_a), .br_addr(br_a), .jmp_addr(jmp_a)
   );

   npc_select #(.AW(AW)) u_sel (
      .branch_en(branch_en), .alu_zero(alu_zero), .jump_en(jump_en),
      .seq_addr(seq_a), .br_addr(br_a), .jmp_addr(jmp_a),
      .nxt_addr(nxt_a)
   );

   npc_reg #(.AW(AW), .RESET_VEC(RESET_VEC), .HAS_STALL(HAS_STALL)) u_reg (
      .clk(clk), .rst(rst), .hold(stall), .d(nxt_a), .q(pc)
   );

   assign pc_plus4 = seq_a;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
   parameter logic [31:0] RESET_VEC = 32'h0
) (
   input logic        clk,
   input logic        rst,
   input logic        stall,
   input logic        branch_en,
   input logic        alu_zero,
   input logic        jump_en,
   input logic [15:0] imm16,
   input logic [25:0] jidx26,
   input logic [31:0] pc,
   input logic [31:0] pc_plus4
);
   logic seen;
   always_ff @(posedge clk) seen <= rst ? 1'b1 : seen;

   p_reset_r1: assert property (@(posedge clk) rst |=> pc == RESET_VEC);

   p_seq_r2: assert property (@(posedge clk) disable iff (rst || !seen)
      (!stall && !jump_en && !(branch_en && alu_zero)) |=> pc == $past(pc) + 32'd4);

   p_plus4_r3: assert property (@(posedge clk) disable iff (!seen)
      pc_plus4 == pc + 32'd4);

   p_branch_r4: assert property (@(posedge clk) disable iff (rst || !seen)
      (!stall && !jump_en && branch_en && alu_zero) |=>
      pc == $past(pc) + 32'd4 + {{14{$past(imm16[15])}}, $past(imm16), 2'b00});

   p_nottaken_r5: assert property (@(posedge clk) disable iff (rst || !seen)
      (!stall && !jump_en && branch_en && !alu_zero) |=> pc == $past(pc_plus4));

   p_jump_r6: assert property (@(posedge clk) disable iff (rst || !seen)
      (!stall && jump_en) |=> pc == {$past(pc_plus4[31:28]), $past(jidx26), 2'b00});

   p_stall_r7: assert property (@(posedge clk) disable iff (rst || !seen)
      stall |=> $stable(pc));

   p_align_r8: assert property (@(posedge clk) disable iff (!seen)
      pc[1:0] == 2'b00);
endmodule

bind npc_unit npc_unit_chk #(.RESET_VEC(RESET_VEC)) u_chk (
   .clk(clk), .rst(rst), .stall(stall), .branch_en(branch_en),
   .alu_zero(alu_zero), .jump_en(jump_en), .imm16(imm16), .jidx26(jidx26),
   .pc(pc), .pc_plus4(pc_plus4)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb;
   localparam int CLK_P = 10;
   localparam logic [31:0] RV = 32'h0;

   logic clk = 0, rst = 1, stall = 0, branch_en = 0, alu_zero = 0, jump_en = 0;
   logic [15:0] imm16 = 0;
   logic [25:0] jidx26 = 0;
   logic [31:0] pc, pc_plus4;
   logic [31:0] model;
   int checks = 0, errors = 0;

   always #(CLK_P/2) clk = ~clk;

   npc_unit u_dut (.clk, .rst, .stall, .branch_en, .alu_zero, .jump_en,
                   .imm16, .jidx26, .pc, .pc_plus4);

   function automatic logic [31:0] f_next(logic [31:0] p, logic r, logic s,
         logic b, logic z, logic j, logic [15:0] o, logic [25:0] ji);
      logic [31:0] q;
      q = p + 32'd4;
      if (r) return RV;
      if (s) return p;
      if (j) return {q[31:28], ji, 2'b00};
      if (b && z) return q + ({{16{o[15]}}, o} << 2);
      return q;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(string req, logic r, logic s, logic b, logic z, logic j,
                       logic [15:0] o, logic [25:0] ji);
      rst = r; stall = s; branch_en = b; alu_zero = z; jump_en = j;
      imm16 = o; jidx26 = ji;
      model = f_next(model, r, s, b, z, j, o, ji);
      @(posedge clk); #1;
      chk(req, pc, model);
      chk("R3", pc_plus4, model + 32'd4);
      chk("R8", {30'd0, pc[1:0]}, 32'd0);
   endtask

   initial begin
      #(CLK_P*200000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'd12345;
      void'($urandom(seed));
      model = 32'hx;
      @(negedge clk);
      step("R1", 1, 0, 0, 0, 0, 0, 0);
      step("R2", 0, 0, 0, 0, 0, 0, 0);
      step("R2", 0, 0, 0, 1, 0, 16'h7fff, 0);
      step("R4", 0, 0, 1, 1, 0, 16'h0010, 0);
      step("R4", 0, 0, 1, 1, 0, 16'hfffe, 0);
      step("R5", 0, 0, 1, 0, 0, 16'h0100, 0);
      step("R6", 0, 0, 1, 1, 1, 16'h0040, 26'h3ffffff);
      step("R7", 0, 1, 1, 1, 1, 16'h0040, 26'h1234567);
      step("R7", 0, 1, 0, 0, 0, 0, 0);
      step("R6", 0, 0, 0, 0, 1, 0, 26'h0abcdef);
      step("R1", 1, 1, 1, 1, 1, 16'h1, 26'h1);
      // put the PC near the top of the address space, then wrap it sequentially
      step("R4", 0, 0, 1, 1, 0, 16'hfffe, 0);
      step("R2", 0, 0, 0, 0, 0, 0, 0);
      step("R2", 0, 0, 0, 0, 0, 0, 0);
      for (int i = 0; i < 400; i++) begin
         logic rr;
         rr = ($urandom % 50) == 0;
         step(rr ? "R1" : "R2_R4_R5_R6_R7", rr, ($urandom % 5) == 0,
              $urandom % 2, $urandom % 2, ($urandom % 4) == 0,
              16'($urandom), 26'($urandom));
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule